// File: doc/BRIEF.md
# Nonvolatile-backed channel command decoder

This block sits behind a serial front end that has already framed and committed a command word. It turns each word into one of seven operations on a bank of twelve 8-bit channel output registers and a small page-organised nonvolatile store. It holds the write-enable latch that guards the store. The store is modelled as a register array, and each programming operation keeps the block busy for a set number of clock cycles. The block drives the channel registers through a one-cycle write strobe with an index and a value. A walk over every channel is announced with a start pulse, and a stored word can be read back as a bit stream.

A command carries a 2-bit control field `{recall, store}` (the same bit order as `cmd_ctrl[1:0]`), a 4-bit channel code, a page number and a data byte. Channel codes 1 to 12 address channels 1 to 12. Code 0 and code 15 carry special meanings for some control values. After reset the block walks every channel from page 0 on its own. A pulse on the external recall input walks every channel from the page on `ext_page`. While any operation that reports busy is in progress, both commands and external recall pulses are dropped.

Top module: `nvdac_cmd_decoder`

## Requirements
- R1: Control 00 with channel 1..12 writes the data byte to that channel: `chan_we` is high for exactly the cycle after acceptance, with `chan_idx` equal to the channel and `chan_data` equal to the byte. The store is not touched and `busy` stays low.
- R2: Control 10 with channel 1..12 loads that channel from the store word at (page, channel). The channel write appears the cycle after acceptance, and `busy` is high for that one cycle.
- R3: Control 10 with channel code 0 starts a walk from the given page. In the first cycle after acceptance `seq_start` is high with no channel write. On the next 12 cycles channels 1 to 12 are written in ascending order with their stored words. `busy` stays high for all 13 cycles.
- R4: Control 11 with channel code 0 sets the write-enable latch. Control 11 with channel code 15 clears it. Neither command drives any output.
- R5: Control 01 with channel 1..12 while write enable is set stores the byte at (page, channel). `busy` is then high for PROG_CYCLES cycles and no channel write occurs. While write enable is clear, the command is dropped and `busy` stays low.
- R6: Control 11 with channel 1..12 reads the stored word out over 14 busy cycles. In the first 6 cycles `rd_strobe` is low and `rd_bit` is 0. In the last 8 cycles `rd_strobe` is high and `rd_bit` carries the word, most significant bit first.
- R7: Channel code 0 under control 00 or 01, codes 13 and 14 under any control, and code 15 under controls 00, 01 and 10 are ignored with no effect on any output or state.
- R8: After reset, write enable is clear and the block walks all 12 channels from page 0, with the same timing as R3.
- R9: An external recall pulse accepted while idle walks all channels from `ext_page` with the timing of R3 and clears write enable. If a command arrives in the same cycle, the command is dropped.
- R10: A command or external recall pulse that arrives while `busy` is high is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Committed command present this cycle |
| cmd_ctrl | input | 2 | Control field {recall, store} |
| cmd_chan | input | 4 | Channel code |
| cmd_page | input | 2 | Store page |
| cmd_data | input | 8 | Data byte |
| ext_recall | input | 1 | External recall-all pulse |
| ext_page | input | 2 | Page used by external recall |
| chan_we | output | 1 | Channel register write strobe |
| chan_idx | output | 4 | Channel being written (1..12) |
| chan_data | output | 8 | Value for the channel register |
| seq_start | output | 1 | First cycle of an all-channel walk |
| rd_bit | output | 1 | Readback serial bit |
| rd_strobe | output | 1 | Readback bit is valid |
| busy | output | 1 | Operation in progress; inputs ignored |

## Verification
Two sources can compete for the same idle cycle: the external recall pulse and a committed command. The bench raises both on one clock edge, together with a direct write to a channel. It then expects a walk from `ext_page`, no write to that channel, and a later store write that is dropped because the latch was cleared. The bench also places commands inside a programming window and inside a readback. It judges these cases by comparing every output, on every cycle, against a behavioural model that treats a busy cycle as a dropped command.

// File: rtl/nvdac_cmd_decoder.sv
module nvdac_cmd_decoder #(
  parameter int CHANS       = 12,
  parameter int PAGES       = 4,
  parameter int DW          = 8,
  parameter int PROG_CYCLES = 40,
  parameter int LEAD_BITS   = 6
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      cmd_valid,
  input  logic [1:0]                cmd_ctrl,
  input  logic [3:0]                cmd_chan,
  input  logic [$clog2(PAGES)-1:0]  cmd_page,
  input  logic [DW-1:0]             cmd_data,
  input  logic                      ext_recall,
  input  logic [$clog2(PAGES)-1:0]  ext_page,
  output logic                      chan_we,
  output logic [3:0]                chan_idx,
  output logic [DW-1:0]             chan_data,
  output logic                      seq_start,
  output logic                      rd_bit,
  output logic                      rd_strobe,
  output logic                      busy
);
  localparam int PW    = $clog2(PAGES);
  localparam int DEPTH = PAGES * CHANS;
  localparam int AW    = $clog2(DEPTH);
  localparam int RBITS = LEAD_BITS + DW;
  localparam int RCW   = $clog2(RBITS);
  localparam int PCW   = $clog2(PROG_CYCLES + 1);
  localparam int WIW   = $clog2(CHANS + 2);

  typedef enum logic [2:0] {S_IDLE, S_ONE, S_WALK, S_READ, S_PROG} st_t;

  st_t             state;
  logic [DW-1:0]   mem [DEPTH];
  logic [WIW-1:0]  widx;
  logic [PW-1:0]   wpage;
  logic            wen;
  logic [RCW-1:0]  rcnt;
  logic [DW-1:0]   rword;
  logic [PCW-1:0]  pcnt;

  logic [AW-1:0] cmd_addr, walk_addr;
  logic [DW-1:0] cmd_word, walk_word;

  assign cmd_addr  = AW'(int'(cmd_page) * CHANS + int'(cmd_chan) - 1);
  assign walk_addr = AW'(int'(wpage) * CHANS + int'(widx) - 1);
  assign cmd_word  = (int'(cmd_addr)  < DEPTH) ? mem[cmd_addr]  : '0;
  assign walk_word = (int'(walk_addr) < DEPTH) ? mem[walk_addr] : '0;

  wire idle     = (state == S_IDLE);
  wire ch_ok    = (cmd_chan >= 4'd1) && (int'(cmd_chan) <= CHANS);
  wire take_ext = idle && ext_recall;
  wire take_cmd = idle && cmd_valid && !ext_recall;

  wire op_direct = take_cmd && cmd_ctrl == 2'b00 && ch_ok;
  wire op_store  = take_cmd && cmd_ctrl == 2'b01 && ch_ok && wen;
  wire op_recall = take_cmd && cmd_ctrl == 2'b10 && ch_ok;
  wire op_all    = take_cmd && cmd_ctrl == 2'b10 && cmd_chan == 4'd0;
  wire op_wen    = take_cmd && cmd_ctrl == 2'b11 && cmd_chan == 4'd0;
  wire op_wdis   = take_cmd && cmd_ctrl == 2'b11 && cmd_chan == 4'hF;
  wire op_read   = take_cmd && cmd_ctrl == 2'b11 && ch_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= S_WALK;
      widx      <= WIW'(1);
      wpage     <= '0;
      wen       <= 1'b0;
      chan_we   <= 1'b0;
      chan_idx  <= '0;
      chan_data <= '0;
      rcnt      <= '0;
      rword     <= '0;
      pcnt      <= '0;
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else begin
      chan_we <= 1'b0;
      case (state)
        S_IDLE: begin
          if (take_ext) begin
            state <= S_WALK;
            widx  <= WIW'(1);
            wpage <= ext_page;
            wen   <= 1'b0;
          end else if (op_direct) begin
            chan_we   <= 1'b1;
            chan_idx  <= cmd_chan;
            chan_data <= cmd_data;
          end else if (op_recall) begin
            chan_we   <= 1'b1;
            chan_idx  <= cmd_chan;
            chan_data <= cmd_word;
            state     <= S_ONE;
          end else if (op_all) begin
            state <= S_WALK;
            widx  <= WIW'(1);
            wpage <= cmd_page;
          end else if (op_wen) begin
            wen <= 1'b1;
          end else if (op_wdis) begin
            wen <= 1'b0;
          end else if (op_read) begin
            state <= S_READ;
            rcnt  <= '0;
            rword <= cmd_word;
          end else if (op_store) begin
            mem[cmd_addr] <= cmd_data;
            state         <= S_PROG;
            pcnt          <= PCW'(PROG_CYCLES - 1);
          end
        end
        S_ONE: state <= S_IDLE;
        S_WALK: begin
          if (int'(widx) == CHANS + 1) begin
            state <= S_IDLE;
          end else begin
            chan_we   <= 1'b1;
            chan_idx  <= 4'(widx);
            chan_data <= walk_word;
            widx      <= widx + 1'b1;
          end
        end
        S_READ: begin
          if (rcnt >= RCW'(LEAD_BITS)) rword <= rword << 1;
          if (rcnt == RCW'(RBITS - 1)) state <= S_IDLE;
          else rcnt <= rcnt + 1'b1;
        end
        S_PROG: begin
          if (pcnt == '0) state <= S_IDLE;
          else pcnt <= pcnt - 1'b1;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assign busy      = !idle;
  assign seq_start = (state == S_WALK) && (widx == WIW'(1));
  assign rd_strobe = (state == S_READ) && (rcnt >= RCW'(LEAD_BITS));
  assign rd_bit    = rd_strobe && rword[DW-1];
endmodule

// File: rtl/nvdac_cmd_decoder_chk.sv
module nvdac_cmd_decoder_chk #(
  parameter int CHANS = 12,
  parameter int PW    = 2,
  parameter int DW    = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cmd_valid,
  input logic [1:0]    cmd_ctrl,
  input logic [3:0]    cmd_chan,
  input logic [PW-1:0] cmd_page,
  input logic [DW-1:0] cmd_data,
  input logic          ext_recall,
  input logic [PW-1:0] ext_page,
  input logic          chan_we,
  input logic [3:0]    chan_idx,
  input logic [DW-1:0] chan_data,
  input logic          seq_start,
  input logic          rd_bit,
  input logic          rd_strobe,
  input logic          busy
);
  AST_WE_CHAN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    chan_we |-> (chan_idx >= 4'd1 && int'(chan_idx) <= CHANS)); // R1
  AST_START_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    seq_start |-> (busy && !chan_we)); // R3
  AST_START_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    seq_start |=> (chan_we && chan_idx == 4'd1)); // R3
  AST_READ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    rd_strobe |-> (busy && !chan_we && !seq_start)); // R6
  AST_READ_BIT_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_strobe |-> !rd_bit); // R6
  AST_EXT_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && ext_recall) |=> seq_start); // R9
  AST_BUSY_CMD_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_strobe && cmd_valid) |=> !chan_we); // R10
endmodule

bind nvdac_cmd_decoder nvdac_cmd_decoder_chk #(.CHANS(CHANS), .PW(PW), .DW(DW)) u_chk (.*);

// File: tb/nvdac_cmd_decoder_tb.sv
module nvdac_cmd_decoder_tb;
  localparam int CHANS = 12;
  localparam int PROG  = 40;

  logic clk = 0, rst_n = 0;
  logic cmd_valid = 0, ext_recall = 0;
  logic [1:0] cmd_ctrl = 0, cmd_page = 0, ext_page = 0;
  logic [3:0] cmd_chan = 0;
  logic [7:0] cmd_data = 0;
  logic chan_we, seq_start, rd_bit, rd_strobe, busy;
  logic [3:0] chan_idx;
  logic [7:0] chan_data;

  always #5 clk = ~clk;

  nvdac_cmd_decoder #(.PROG_CYCLES(PROG)) u_dut (.*);

  typedef struct { bit we; int idx; int data; bit busy; bit ss; bit rs; bit rb; string tag; } exp_t;
  exp_t q[$];
  exp_t cur;
  int store[4*CHANS];
  bit m_wen;
  int checks = 0, errors = 0;
  string scen = "R8";
  bit done = 0;

  function automatic exp_t mk(bit we, int idx, int data, bit bz, string tag);
    exp_t e;
    e.we = we; e.idx = idx; e.data = data; e.busy = bz;
    e.ss = 0; e.rs = 0; e.rb = 0; e.tag = tag;
    return e;
  endfunction

  function automatic void walk(int p, string tag);
    cur = mk(0, 0, 0, 1, tag);
    cur.ss = 1;
    for (int k = 1; k <= CHANS; k++) q.push_back(mk(1, k, store[p*CHANS+k-1], 1, tag));
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      foreach (store[i]) store[i] = 0;
      m_wen = 0;
      q.delete();
      walk(0, "R8");
    end else begin
      bit acc;
      int c, a;
      acc = !cur.busy && (ext_recall || cmd_valid);
      if (q.size() > 0) cur = q.pop_front(); else cur = mk(0, 0, 0, 0, scen);
      if (acc) begin
        c = int'(cmd_chan);
        a = int'(cmd_page) * CHANS + c - 1;
        if (ext_recall) begin
          walk(int'(ext_page), "R9");
          m_wen = 0;
        end else if (c >= 1 && c <= CHANS) begin
          case (cmd_ctrl)
            2'b00: cur = mk(1, c, int'(cmd_data), 0, "R1");
            2'b01: if (m_wen) begin
              store[a] = int'(cmd_data);
              cur = mk(0, 0, 0, 1, "R5");
              for (int k = 1; k < PROG; k++) q.push_back(mk(0, 0, 0, 1, "R5"));
            end
            2'b10: cur = mk(1, c, store[a], 1, "R2");
            default: begin
              cur = mk(0, 0, 0, 1, "R6");
              for (int k = 1; k < 14; k++) begin
                exp_t e;
                e = mk(0, 0, 0, 1, "R6");
                if (k >= 6) begin e.rs = 1; e.rb = store[a][13-k]; end
                q.push_back(e);
              end
            end
          endcase
        end else if (cmd_ctrl == 2'b10 && c == 0) walk(int'(cmd_page), "R3");
        else if (cmd_ctrl == 2'b11 && c == 0) m_wen = 1;
        else if (cmd_ctrl == 2'b11 && c == 15) m_wen = 0;
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      bit bad;
      checks++;
      bad = (chan_we !== cur.we) || (busy !== cur.busy) || (seq_start !== cur.ss) ||
            (rd_strobe !== cur.rs) || (rd_bit !== cur.rb) ||
            (cur.we && (int'(chan_idx) != cur.idx || int'(chan_data) != cur.data));
      if (bad) begin
        errors++;
        $display("FAIL %s t=%0t actual we=%b idx=%0d data=%h busy=%b ss=%b rs=%b rb=%b expected we=%b idx=%0d data=%h busy=%b ss=%b rs=%b rb=%b",
          cur.tag, $time, chan_we, chan_idx, chan_data, busy, seq_start, rd_strobe, rd_bit,
          cur.we, cur.idx, cur.data[7:0], cur.busy, cur.ss, cur.rs, cur.rb);
      end
    end
  end

  task automatic cmd(input logic [1:0] ctrl, input int ch, input int pg, input int d, input string tag);
    @(negedge clk);
    scen = tag;
    cmd_ctrl = ctrl; cmd_chan = 4'(ch); cmd_page = 2'(pg); cmd_data = 8'(d);
    cmd_valid = 1;
    @(negedge clk);
    cmd_valid = 0;
  endtask

  task automatic gap(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic expect_bit(input logic act, input logic exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  initial begin
    gap(3);
    expect_bit(busy, 1'b1, "R8 busy in reset");
    expect_bit(chan_we, 1'b0, "R8 no write in reset");
    rst_n = 1;
    gap(20);
    cmd(2'b00, 3, 0, 8'hA5, "R1");
    cmd(2'b00, 12, 0, 8'h01, "R1");
    gap(2);
    cmd(2'b00, 0, 0, 8'hFF, "R7");
    cmd(2'b00, 13, 0, 8'hFF, "R7");
    cmd(2'b10, 14, 1, 0, "R7");
    cmd(2'b11, 13, 1, 0, "R7");
    cmd(2'b01, 0, 1, 8'h99, "R7");
    cmd(2'b10, 15, 1, 0, "R7");
    gap(3);
    cmd(2'b01, 2, 1, 8'h3C, "R5");
    gap(3);
    cmd(2'b11, 2, 1, 0, "R6");
    gap(16);
    cmd(2'b11, 0, 0, 0, "R4");
    cmd(2'b01, 2, 1, 8'h3C, "R5");
    gap(PROG + 3);
    cmd(2'b11, 2, 1, 0, "R6");
    gap(16);
    cmd(2'b01, 12, 3, 8'h81, "R5");
    cmd(2'b00, 5, 0, 8'h44, "R10");
    expect_bit(chan_we, 1'b0, "R10 write during programming");
    cmd(2'b11, 12, 3, 0, "R10");
    gap(PROG);
    cmd(2'b10, 12, 3, 0, "R2");
    gap(3);
    cmd(2'b11, 12, 3, 0, "R6");
    gap(8);
    cmd(2'b00, 7, 0, 8'h12, "R10");
    expect_bit(chan_we, 1'b0, "R10 write during readback");
    gap(10);
    cmd(2'b11, 15, 0, 0, "R4");
    cmd(2'b01, 1, 0, 8'h77, "R4");
    gap(3);
    cmd(2'b11, 1, 0, 0, "R4");
    gap(16);
    cmd(2'b11, 0, 0, 0, "R4");
    for (int k = 1; k <= CHANS; k++) begin
      cmd(2'b01, k, 2, k * 17, "R5");
      gap(PROG + 1);
    end
    cmd(2'b10, 0, 2, 0, "R3");
    gap(16);
    @(negedge clk);
    scen = "R9";
    ext_page = 2'd2; ext_recall = 1;
    cmd_ctrl = 2'b00; cmd_chan = 4'd4; cmd_data = 8'hEE; cmd_valid = 1;
    @(negedge clk);
    ext_recall = 0; cmd_valid = 0;
    gap(3);
    @(negedge clk);
    ext_page = 2'd3; ext_recall = 1;
    @(negedge clk);
    ext_recall = 0;
    gap(12);
    cmd(2'b01, 1, 0, 8'h55, "R9");
    gap(3);
    cmd(2'b11, 1, 0, 0, "R9");
    gap(20);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule